// File: doc/BRIEF.md
# Master-to-Sample Clock Ratio Detector

This block runs on the master clock. It measures how many master-clock cycles pass between successive rising edges of the frame (sample-rate) clock. Each measured period is matched against six supported oversampling ratios. A ratio is accepted when the period lies no more than 32 cycles from it, so drift and jitter are absorbed. Downstream filter timing receives a 3-bit ratio code together with a valid flag.

When a period misses every window, or the frame clock stops, the block raises its mute output at once and clears the valid flag. Conversion stays stopped until two consecutive periods fall into the same ratio window. The frame clock is brought into the master domain through a synchronizer. A saturating counter turns a missing frame clock into an out-of-range reading.

Top module: `ratio_detector`

## Requirements
- R1: While reset is held, and on the first cycle after it, `mute` is 1, `ratioValid` is 0 and `ratioCode` is 0.
- R2: Ratio codes follow ascending ratio order: 0=128, 1=192, 2=256, 3=384, 4=512, 5=768. After two consecutive periods that classify to the same ratio, `ratioCode` shows that code and mute is released.
- R3: A period counts as belonging to a ratio when it is no more than 32 cycles from the nominal value, inclusive at both ends. A period 33 cycles away that lies in no other window is out of range.
- R4: Some periods lie inside two windows, for example 160 and 224. Such a period classifies to the lower of the two ratios.
- R5: An out-of-range period raises `mute` at the update that ends that period.
- R6: While locked, periods that move about inside the locked window leave `ratioCode` unchanged and keep `mute` low.
- R7: One valid period alone does not release mute. Periods that alternate between two different valid ratios never release it.
- R8: The period counter saturates at 801, which is the largest ratio plus 32 plus 1. When the frame clock stops, mute rises once the count reaches saturation, with no frame edge needed. A saturated period is out of range.
- R9: `ratioValid` is always the inverse of `mute`, and `ratioCode` is 0 while muted.
- R10: When a locked stream changes to a different valid ratio, mute rises on the first period of the new ratio. The block relocks to the new code on the second such period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameClk | input | 1 | Frame (sample-rate) clock, asynchronous to clk |
| ratioCode | output | 3 | Detected ratio code, 0 while muted |
| ratioValid | output | 1 | High while a ratio is locked |
| mute | output | 1 | Stop-and-mute request |

## Verification
On every cycle, the assertions check three things. The counter never exceeds its saturation value. Every accepted period really lies inside the window of its code and outside the window of the next lower ratio. Mute follows a bad period, a timeout and a code change while locked, and it falls only after a period that matched the held candidate. Other behaviours need the bench's scenarios: the exact window edges at plus and minus 32 and 33 for all six ratios, tie resolution, the two-period release, the timing of a stopped frame clock, and relocking after a ratio change.

// File: rtl/ratio_det_pkg.sv
package ratio_det_pkg;

  localparam int NUM_RATIOS = 6;
  localparam int CODE_W     = 3;

  // Strobes from the period meter to the lock control.
  typedef struct packed {
    logic              newPeriod;
    logic              inWindow;
    logic [CODE_W-1:0] code;
    logic              timeout;
  } meas_t;

  // Ascending ratios: even index 128<<k, odd index 192<<k.
  function automatic int nominalRatio(input int idx);
    return (((idx % 2) != 0) ? 192 : 128) << (idx / 2);
  endfunction

endpackage

// File: rtl/ratio_classifier.sv
module ratio_classifier
  import ratio_det_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 32
) (
  input  logic [CNT_W-1:0]  period,
  output logic              hit,
  output logic [CODE_W-1:0] code
);

  logic [31:0]           periodExt;
  logic [NUM_RATIOS-1:0] inWin;

  assign periodExt = 32'(period);

  generate
    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
      localparam int NOM = nominalRatio(g);
      localparam int LO  = (NOM > TOL) ? NOM - TOL : 0;
      localparam int HI  = NOM + TOL;
      assign inWin[g] = (periodExt >= 32'(LO)) && (periodExt <= 32'(HI));
    end
  endgenerate

  assign hit = |inWin;

  // Lowest ratio wins where windows overlap.
  always_comb begin
    code = '0;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (inWin[i]) code = CODE_W'(i);
    end
  end

endmodule

// File: rtl/ratio_period_meter.sv
module ratio_period_meter
  import ratio_det_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int TOL         = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  frameClk,
  output meas_t meas
);

  localparam int              SAT_VAL = nominalRatio(NUM_RATIOS - 1) + TOL + 1;
  localparam logic [CNT_W-1:0] SAT    = CNT_W'(SAT_VAL);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   frameQ;
  logic                   rise;
  logic [CNT_W-1:0]       cnt;
  logic                   hit;
  logic [CODE_W-1:0]      code;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '0;
      frameQ <= 1'b0;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], frameClk};
      frameQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rise = syncQ[SYNC_STAGES-1] & ~frameQ;

  // cnt holds the cycles since the last rise; it starts saturated so the first
  // partial period after reset reads as out of range.
  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= SAT;
    else if (rise)       cnt <= CNT_W'(1);
    else if (cnt != SAT) cnt <= cnt + CNT_W'(1);
  end

  ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) i_classifier (
    .period(cnt),
    .hit   (hit),
    .code  (code)
  );

  assign meas.newPeriod = rise;
  assign meas.inWindow  = hit;
  assign meas.code      = code;
  assign meas.timeout   = (cnt == SAT) && !rise;

  a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= SAT);

  a_r3_window_holds: assert property (@(posedge clk) disable iff (!rstN)
    (meas.newPeriod && meas.inWindow) |->
      ((int'(cnt) >= nominalRatio(int'(meas.code)) - TOL) &&
       (int'(cnt) <= nominalRatio(int'(meas.code)) + TOL)));

  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    (meas.newPeriod && meas.inWindow && meas.code != '0) |->
      (int'(cnt) > nominalRatio(int'(meas.code) - 1) + TOL));

endmodule

// File: rtl/ratio_lock_ctrl.sv
module ratio_lock_ctrl
  import ratio_det_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  meas_t             meas,
  output logic [CODE_W-1:0] ratioCode,
  output logic              ratioValid,
  output logic              mute
);

  typedef enum logic [1:0] { ST_MUTED, ST_ARMED, ST_LOCKED } lock_st_e;

  lock_st_e          state;
  logic [CODE_W-1:0] candCode;
  logic [CODE_W-1:0] lockCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_MUTED;
      candCode <= '0;
      lockCode <= '0;
    end else if (meas.timeout) begin
      state <= ST_MUTED;
    end else if (meas.newPeriod) begin
      if (!meas.inWindow) begin
        state <= ST_MUTED;
      end else begin
        unique case (state)
          ST_MUTED: begin
            candCode <= meas.code;
            state    <= ST_ARMED;
          end
          ST_ARMED: begin
            if (meas.code == candCode) begin
              lockCode <= meas.code;
              state    <= ST_LOCKED;
            end else begin
              candCode <= meas.code;
            end
          end
          ST_LOCKED: begin
            if (meas.code != lockCode) begin
              candCode <= meas.code;
              state    <= ST_ARMED;
            end
          end
          default: state <= ST_MUTED;
        endcase
      end
    end
  end

  assign mute       = (state != ST_LOCKED);
  assign ratioValid = (state == ST_LOCKED);
  assign ratioCode  = (state == ST_LOCKED) ? lockCode : '0;

  a_r5_bad_period_mutes: assert property (@(posedge clk) disable iff (!rstN)
    (meas.newPeriod && !meas.inWindow) |=> mute);

  a_r8_timeout_mutes: assert property (@(posedge clk) disable iff (!rstN)
    meas.timeout |=> mute);

  a_r7_release_on_match: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mute) |-> $past(meas.newPeriod && meas.inWindow && !meas.timeout &&
                          meas.code == candCode));

  a_r6_locked_code_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!mute && $past(!mute)) |-> $stable(ratioCode));

  a_r10_change_mutes: assert property (@(posedge clk) disable iff (!rstN)
    (!mute && meas.newPeriod && meas.inWindow && meas.code != ratioCode) |=> mute);

endmodule

// File: rtl/ratio_detector.sv
module ratio_detector
  import ratio_det_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int TOL         = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameClk,
  output logic [CODE_W-1:0] ratioCode,
  output logic              ratioValid,
  output logic              mute
);

  meas_t meas;

  ratio_period_meter #(.CNT_W(CNT_W), .TOL(TOL), .SYNC_STAGES(SYNC_STAGES)) i_meter (
    .clk     (clk),
    .rstN    (rstN),
    .frameClk(frameClk),
    .meas    (meas)
  );

  ratio_lock_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .meas      (meas),
    .ratioCode (ratioCode),
    .ratioValid(ratioValid),
    .mute      (mute)
  );

endmodule

// File: tb/test_ratio_detector.sv
module test_ratio_detector;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameClk = 1'b0;
  logic [2:0] ratioCode;
  logic       ratioValid;
  logic       mute;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ratio_detector i_ratio_detector (
    .clk(clk), .rstN(rstN), .frameClk(frameClk),
    .ratioCode(ratioCode), .ratioValid(ratioValid), .mute(mute)
  );

  function automatic int nomOf(input int i);
    return (((i % 2) != 0) ? 192 : 128) << (i / 2);
  endfunction

  // Expected class of a period, lowest ratio first; -1 when out of range.
  function automatic int classify(input int n);
    for (int i = 0; i < 6; i++) begin
      if (n >= nomOf(i) - 32 && n <= nomOf(i) + 32) return i;
    end
    return -1;
  endfunction

  task automatic check(input bit expMute, input int expCode, input string tag);
    int expC;
    expC = expMute ? 0 : expCode;
    testsRun++;
    if (mute !== expMute || ratioValid !== !expMute || int'(ratioCode) != expC) begin
      testsFailed++;
      $display("FAIL %s R9: mute=%0b valid=%0b code=%0d expected mute=%0b valid=%0b code=%0d",
               tag, mute, ratioValid, ratioCode, expMute, !expMute, expC);
    end
  endtask

  // One frame period of n cycles; the check at cycle 6 sees the result of the
  // period that this rising edge closes.
  task automatic runPeriod(input int n, input bit doChk, input bit expMute,
                           input int expCode, input string tag);
    @(negedge clk);
    frameClk = 1'b1;
    for (int c = 1; c < n; c++) begin
      @(negedge clk);
      if (c == n / 2) frameClk = 1'b0;
      if (c == 6 && doChk) check(expMute, expCode, tag);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !finished) begin
      finished = 1'b1;
      testsFailed++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int offs[7];
    int n;
    int e;
    offs = '{-33, -32, -1, 0, 1, 32, 33};

    // R1 reset state
    repeat (4) @(negedge clk);
    check(1'b1, 0, "R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    check(1'b1, 0, "R1 after reset");

    // R2 R3 R4 R5 R7 sweep: every ratio at both window edges and just outside
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < 7; k++) begin
        n = nomOf(i) + offs[k];
        e = classify(n);
        runPeriod(60, 1'b0, 1'b1, 0, "");
        runPeriod(n, 1'b1, 1'b1, 0, "R5 bad period mutes");
        runPeriod(n, 1'b1, 1'b1, 0, "R7 single good period keeps mute");
        if (e < 0)
          runPeriod(60, 1'b1, 1'b1, 0, "R3 beyond window stays muted");
        else if (n == 160 || n == 224)
          runPeriod(60, 1'b1, 1'b0, e, "R4 overlap picks lower ratio");
        else
          runPeriod(60, 1'b1, 1'b0, e, "R2 R3 lock to ratio code");
      end
    end

    // R8 stopped frame clock
    runPeriod(60, 1'b0, 1'b1, 0, "");
    runPeriod(768, 1'b1, 1'b1, 0, "R5 bad period mutes");
    runPeriod(768, 1'b1, 1'b1, 0, "R7 single good period keeps mute");
    runPeriod(768, 1'b1, 1'b0, 5, "R2 lock at 768");
    repeat (13) @(negedge clk);
    check(1'b0, 5, "R8 not yet saturated");
    repeat (60) @(negedge clk);
    check(1'b1, 0, "R8 saturation mutes without edge");
    runPeriod(256, 1'b1, 1'b1, 0, "R8 saturated period out of range");
    runPeriod(256, 1'b1, 1'b1, 0, "R7 single good period keeps mute");
    runPeriod(255, 1'b1, 1'b0, 2, "R2 lock at 256");

    // R6 jitter inside the locked window
    runPeriod(257, 1'b1, 1'b0, 2, "R6 jitter 255");
    runPeriod(230, 1'b1, 1'b0, 2, "R6 jitter 257");
    runPeriod(282, 1'b1, 1'b0, 2, "R6 jitter 230");
    runPeriod(256, 1'b1, 1'b0, 2, "R6 jitter 282");

    // R10 ratio change while locked
    runPeriod(384, 1'b1, 1'b0, 2, "R6 jitter 256");
    runPeriod(384, 1'b1, 1'b1, 0, "R10 new ratio mutes");
    runPeriod(128, 1'b1, 1'b0, 3, "R10 relock to new ratio");

    // R7 alternating valid ratios never release
    runPeriod(192, 1'b1, 1'b1, 0, "R10 change to 128 mutes");
    runPeriod(128, 1'b1, 1'b1, 0, "R7 alternation 192");
    runPeriod(192, 1'b1, 1'b1, 0, "R7 alternation 128");
    runPeriod(512, 1'b1, 1'b1, 0, "R7 alternation 192");
    runPeriod(512, 1'b1, 1'b1, 0, "R7 first 512");
    runPeriod(100, 1'b1, 1'b0, 4, "R2 lock at 512");

    // R1 reset while locked
    @(negedge clk);
    rstN = 1'b0;
    frameClk = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b1, 0, "R1 reset while locked");
    rstN = 1'b1;
    @(negedge clk);
    check(1'b1, 0, "R1 after second reset");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule